// File: doc/BRIEF.md
# Shared GPIO Port with Converter Pin Claim

This block is an 8-bit general-purpose I/O port. Software reaches two registers over a small register bus: a data latch that holds the values driven on the pins, and a direction register in which a 1 makes a pin an output. The block drives pin values and output enables toward the pads. It samples the pad inputs through a two-flop synchronizer.

An analog converter can claim any one pin. It does this by presenting a channel number with a valid flag. The claim is registered. From the next clock edge, the claimed pin has its driver turned off and its driven value held at 0, and it reads back as 0. Register writes to that pin's latch and direction bits are still stored. They do not reach the pin until the converter lets go of it. At that point the stored values take effect on the next edge.

All other pins keep working as ordinary GPIO while a claim is active.

Top module: `gpio_adc_share`

## Requirements
- R1: After reset, every latch bit and every direction bit is 0, no pin is claimed, `pin_oe` is all zeros and `pin_out` is all zeros.
- R2: A write with `reg_wr` high at a rising edge stores `reg_wdata`. With `reg_addr` = 0 it goes to the data latch, and with `reg_addr` = 1 it goes to the direction register. A read with `reg_addr` = 1 returns the stored direction bits.
- R3: For an unclaimed pin, `pin_oe` equals its direction bit and `pin_out` equals its latch bit.
- R4: A read with `reg_addr` = 0 returns the latch bit for an unclaimed pin whose direction bit is 1.
- R5: For an unclaimed pin whose direction bit is 0, a data read returns the pin input. A change on the input becomes visible after two rising edges and not after one.
- R6: One edge after `ana_valid` is sampled high, the pin numbered by `ana_sel` has `pin_oe` at 0, whatever its direction bit. No claim takes effect before that edge.
- R7: While a pin is claimed, writes to the latch or the direction register leave that pin's `pin_oe` and `pin_out` at 0. The written bits are still stored, and a direction read shows them.
- R8: While a pin is claimed, a data read returns 0 in that pin's bit position.
- R9: One edge after the claim is dropped or moved to another pin, the released pin is driven again from its stored latch and direction bits.
- R10: Pins other than the claimed one keep their output enable, driven value and read value while a claim is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 data latch, 1 direction |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Read data for the selected register |
| pin_in | input | WIDTH | Pad input levels |
| pin_out | output | WIDTH | Pad output values |
| pin_oe | output | WIDTH | Pad output enables, 1 drives |
| ana_sel | input | SEL_W | Pin number claimed by the converter |
| ana_valid | input | 1 | Converter claim is active |

## Verification
A wrong claim register shows up one edge after the select changes. Either a claimed pin keeps driving, seen on `pin_oe` and `pin_out`, or a pin that is not claimed goes quiet and reads 0. A corrupted latch or direction bit is visible at once on the pad outputs of an unclaimed pin. On a claimed pin it stays hidden until release. A direction read exposes it before release, and the pads show it one edge after release. A fault in the synchronizer appears as a data read that changes after the wrong number of edges.

// File: rtl/gpio_adc_share.sv
module gpio_adc_share #(
  parameter int WIDTH = 8,
  parameter int SEL_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  input  logic [SEL_W-1:0] ana_sel,
  input  logic             ana_valid
);
  logic [WIDTH-1:0] lat_q, dir_q, sync1_q, sync2_q, claim_q, claim_d, port_rd;

  always_comb begin
    claim_d = '0;
    for (int i = 0; i < WIDTH; i++)
      if (ana_valid && ana_sel == SEL_W'(i)) claim_d[i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lat_q   <= '0;
      dir_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
      claim_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      claim_q <= claim_d;
      if (reg_wr && !reg_addr) lat_q <= reg_wdata;
      if (reg_wr &&  reg_addr) dir_q <= reg_wdata;
    end

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      assign port_rd[g] = claim_q[g] ? 1'b0 : (dir_q[g] ? lat_q[g] : sync2_q[g]);
    end
  endgenerate

  assign pin_oe    = dir_q & ~claim_q;
  assign pin_out   = lat_q & ~claim_q;
  assign reg_rdata = reg_addr ? dir_q : port_rd;
endmodule

// File: rtl/gpio_adc_share_chk.sv
module gpio_adc_share_chk #(
  parameter int WIDTH = 8,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_addr,
  input logic [WIDTH-1:0] reg_rdata,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic [SEL_W-1:0] ana_sel,
  input logic             ana_valid
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (pin_oe == '0 && pin_out == '0));

  assert_claim_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ana_valid |=> !pin_oe[$past(ana_sel)]);

  assert_claim_out_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ana_valid |=> !pin_out[$past(ana_sel)]);

  assert_claim_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ana_valid |=> (reg_addr || !reg_rdata[$past(ana_sel)]));

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_chk
      assert_out_reads_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_addr && pin_oe[i]) |-> (reg_rdata[i] == pin_out[i]));
    end
  endgenerate
endmodule

bind gpio_adc_share gpio_adc_share_chk #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .ana_sel(ana_sel), .ana_valid(ana_valid)
);

// File: tb/gpio_adc_share_tb.sv
module gpio_adc_share_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] pin_in = 8'h0F;
  logic [7:0] pin_out, pin_oe;
  logic [2:0] ana_sel = '0;
  logic       ana_valid = 1'b0;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_adc_share u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .ana_sel(ana_sel), .ana_valid(ana_valid)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    repeat (2) @(negedge clk);
    check("R1 oe", pin_oe, 8'h00);
    check("R1 out", pin_out, 8'h00);
    rd(1'b1, v); check("R1 dir", v, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(1'b0, v); check("R1 data", v, 8'h0F);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(1'b1, 8'hF0);
    wr(1'b0, 8'hA5);
    rd(1'b1, v); check("R2 dir readback", v, 8'hF0);
    check("R3 oe", pin_oe, 8'hF0);
    check("R3 out", pin_out, 8'hA5);
    rd(1'b0, v);
    check("R4 latch read", v & 8'hF0, 8'hA0);
    check("R5 pin read", v & 8'h0F, 8'h0F);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    @(negedge clk); pin_in = 8'h03;
    @(negedge clk); rd(1'b0, v); check("R5 one edge", v & 8'h0F, 8'h0F);
    @(negedge clk); rd(1'b0, v); check("R5 two edges", v & 8'h0F, 8'h03);
  endtask

  task automatic t_claim;
    logic [7:0] v;
    @(negedge clk); ana_sel = 3'd5; ana_valid = 1'b1;
    #1 check("R6 not before edge", pin_oe, 8'hF0);
    @(negedge clk);
    check("R6 oe", pin_oe, 8'hD0);
    check("R10 out", pin_out, 8'h85);
    rd(1'b0, v); check("R8 data read", v, 8'h83);
  endtask

  task automatic t_claim_write;
    logic [7:0] v;
    wr(1'b0, 8'hFF);
    wr(1'b1, 8'hFF);
    check("R7 oe", pin_oe, 8'hDF);
    check("R7 out", pin_out, 8'hDF);
    rd(1'b1, v); check("R7 dir stored", v, 8'hFF);
    rd(1'b0, v); check("R8 data read", v, 8'hDF);
  endtask

  task automatic t_move;
    logic [7:0] v;
    @(negedge clk); ana_sel = 3'd1;
    @(negedge clk);
    check("R9 moved oe", pin_oe, 8'hFD);
    check("R9 moved out", pin_out, 8'hFD);
    wr(1'b1, 8'h00);
    check("R10 oe", pin_oe, 8'h00);
    rd(1'b0, v); check("R8 input pin", v, 8'h01);
  endtask

  task automatic t_release;
    logic [7:0] v;
    @(negedge clk); ana_valid = 1'b0;
    @(negedge clk);
    rd(1'b0, v); check("R9 read", v, 8'h03);
    wr(1'b1, 8'hFF);
    check("R9 oe", pin_oe, 8'hFF);
    check("R9 out", pin_out, 8'hFF);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_sync();
    t_claim();
    t_claim_write();
    t_move();
    t_release();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule